// File: doc/BRIEF.md
# SDRAM Periodic Refresh Sequencer

This block schedules auto-refresh cycles for an SDRAM bus. An interval timer counts clock cycles up to a programmable 14-bit refresh interval. When the interval runs out, the block raises a request to the memory arbiter and holds it until a grant arrives. The arbiter grants only once the access controller has drained any access in flight, so a slow access delays the refresh without moving the next deadline.

After a grant the block owns the command pins and runs a fixed sequence. It issues a precharge-all and stays in a precharge phase of twice the precharge-to-activate setting. It then waits that setting in clocks and issues an auto-refresh, which occupies four cycles. One dead cycle follows, and then it hands the bus back. With a setting of p (zero is treated as one), one refresh holds the bus for 3p+5 cycles: 11 cycles for p=2. The interval timer restarts when a request is raised, not when a refresh finishes. Waiting for the grant therefore never stretches the refresh period. An interval of zero switches refresh off.

Top module: `sdram_refresh_seq`

## Requirements
- R1: During and right after reset `ref_req` and `ref_active` are 0 and all four command pins are 1. Whenever `ref_active` is 0 the pins stay all 1 (deselect).
- R2: With a non-zero interval I, `ref_req` first rises I clock edges after reset release. Later rises follow at multiples of I counted from that first rise, whatever the grant delay, as long as each refresh ends before the next deadline.
- R3: With the interval set to 0, no request is raised and no command is driven.
- R4: Once raised, `ref_req` stays 1 until a cycle where `ref_gnt` is 1. While it waits, the command pins stay deselected.
- R5: In the cycle after a grant, `ref_req` is 0 and `ref_active` is 1. The pins carry precharge-all: {cs_n,ras_n,cas_n,we_n} = 0010.
- R6: With p' = max(p,1), the precharge phase lasts 2p' cycles and the wait lasts p' cycles. Auto-refresh ({cs_n,ras_n,cas_n,we_n} = 0001) appears in sequence cycle 3p'+1.
- R7: The refresh phase lasts 4 cycles and is followed by one dead cycle, so `ref_active` is 1 for exactly 3p'+5 cycles. Every sequence cycle that carries neither command is a NOP (0111). After the sequence the pins return to 1111.
- R8: Deadlines that pass while a request is already pending are merged into that one request. No extra request follows the refresh.
- R9: A deadline that passes during a running sequence produces no request while `ref_active` is 1. The request is raised in the first cycle after the sequence.
- R10: A deadline that falls on the same edge as a grant leaves a new request pending. It appears right after the granted sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_interval | input | 14 | Refresh interval in cycles, 0 disables |
| cfg_pre_wait | input | 4 | Precharge-to-activate wait in cycles, 0 treated as 1 |
| ref_gnt | input | 1 | Grant from the arbiter, sampled while `ref_req` is 1 |
| ref_req | output | 1 | Refresh request to the arbiter |
| ref_active | output | 1 | Block owns the command pins |
| sd_cs_n | output | 1 | SDRAM chip select, active low |
| sd_ras_n | output | 1 | SDRAM row strobe, active low |
| sd_cas_n | output | 1 | SDRAM column strobe, active low |
| sd_we_n | output | 1 | SDRAM write enable, active low |

## Verification
A refresh deadline and a grant can fall on the same clock edge. A deadline can also fall inside a running sequence. The bench provokes the first case by withholding the grant until exactly one interval after the first request, and the second by choosing an interval shorter than one sequence. In both cases it judges the result from when `ref_req` goes low and comes back relative to `ref_active`. It also confirms that requests merged while a grant is held off leave no extra refresh behind and do not shift the next deadline.

// File: rtl/sdram_ref_pkg.sv
// Shared types for the SDRAM refresh sequencer.
// Assumes: command pins are active low and decoded by the SDRAM as {cs_n,ras_n,cas_n,we_n}.
package sdram_ref_pkg;

    // Sequence phases of one refresh event
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_WAIT,
        SEQ_REF,
        SEQ_DEAD
    } seq_state_e;

    // Command the sequencer wants on the pins in the current cycle
    typedef enum logic [1:0] {
        ISSUE_DESEL,
        ISSUE_NOP,
        ISSUE_PRE,
        ISSUE_REF
    } issue_e;

    // SDRAM command pin bundle
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sd_cmd_t;

    localparam sd_cmd_t CMD_DESEL     = 4'b1111;
    localparam sd_cmd_t CMD_NOP       = 4'b0111;
    localparam sd_cmd_t CMD_PRECHARGE = 4'b0010;
    localparam sd_cmd_t CMD_REFRESH   = 4'b0001;

endpackage

// File: rtl/ref_interval_timer.sv
// Interval timer and request flag.
// Counts cycles up to the programmed interval. On expiry it reloads to zero and
// sets the pending flag. Reloading at expiry (not at refresh completion) keeps
// grant delays from adding up. Expiries while pending merge into one request.
// Assumes: take is high only while pending is high.
module ref_interval_timer #(
    parameter int INTERVAL_W = 14
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] cfg_interval,
    input  logic                  take,
    output logic                  pending
);

    logic [INTERVAL_W-1:0] cnt;
    logic                  enabled;
    logic                  expire;

    assign enabled = (cfg_interval != '0);
    assign expire  = enabled && (cnt >= cfg_interval - INTERVAL_W'(1));

    // Free-running cycle counter, cleared on expiry or while disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !enabled || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + INTERVAL_W'(1);
        end
    end

    // Pending flag: a new deadline wins over a grant taken on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (expire) begin
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !take) |=> pending); // R4

    AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled && !pending) |=> !pending); // R3

endmodule

// File: rtl/ref_seq_fsm.sv
// Refresh sequence controller.
// On start it runs a precharge phase of 2p cycles, a wait of p cycles, a refresh
// phase of CMD_CYCLES cycles and one dead cycle (p = wait setting, 0 read as 1).
// The wait setting is latched at start so a change mid-sequence has no effect.
// Assumes: start is only high while busy is low.
module ref_seq_fsm
    import sdram_ref_pkg::*;
#(
    parameter int WAIT_W     = 4,
    parameter int CMD_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] cfg_pre_wait,
    output logic              busy,
    output issue_e            issue
);

    localparam int CMD_W = $clog2(CMD_CYCLES) + 1;
    localparam int PH_W  = (WAIT_W + 1 > CMD_W) ? WAIT_W + 1 : CMD_W;

    seq_state_e        state;
    logic [PH_W-1:0]   ph;
    logic              fresh;
    logic [WAIT_W-1:0] p_eff;
    logic [WAIT_W-1:0] p_lat;

    assign p_eff = (cfg_pre_wait == '0) ? WAIT_W'(1) : cfg_pre_wait;

    // Phase sequencing with a down-counter per phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_IDLE;
            ph    <= '0;
            fresh <= 1'b0;
            p_lat <= '0;
        end else begin
            fresh <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state <= SEQ_PRE;
                        ph    <= (PH_W'(p_eff) << 1) - PH_W'(1);
                        fresh <= 1'b1;
                        p_lat <= p_eff;
                    end
                end
                SEQ_PRE: begin
                    if (ph == '0) begin
                        state <= SEQ_WAIT;
                        ph    <= PH_W'(p_lat) - PH_W'(1);
                    end else begin
                        ph <= ph - PH_W'(1);
                    end
                end
                SEQ_WAIT: begin
                    if (ph == '0) begin
                        state <= SEQ_REF;
                        ph    <= PH_W'(CMD_CYCLES - 1);
                        fresh <= 1'b1;
                    end else begin
                        ph <= ph - PH_W'(1);
                    end
                end
                SEQ_REF: begin
                    if (ph == '0) begin
                        state <= SEQ_DEAD;
                    end else begin
                        ph <= ph - PH_W'(1);
                    end
                end
                SEQ_DEAD: state <= SEQ_IDLE;
                default:  state <= SEQ_IDLE;
            endcase
        end
    end

    assign busy = (state != SEQ_IDLE);

    // Command choice: a command only in the first cycle of its phase
    always_comb begin
        if (!busy) begin
            issue = ISSUE_DESEL;
        end else if (fresh && state == SEQ_PRE) begin
            issue = ISSUE_PRE;
        end else if (fresh && state == SEQ_REF) begin
            issue = ISSUE_REF;
        end else begin
            issue = ISSUE_NOP;
        end
    end

    AST_START_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == SEQ_PRE && fresh)); // R5

    AST_REF_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_REF && fresh) |-> ($past(state) == SEQ_WAIT)); // R6

    AST_DEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_DEAD) |=> (state == SEQ_IDLE)); // R7

endmodule

// File: rtl/ref_cmd_encode.sv
// Maps the sequencer's command choice onto the SDRAM command pin bundle.
// Assumes: pins are deselected whenever the sequencer does not own the bus.
module ref_cmd_encode
    import sdram_ref_pkg::*;
(
    input  issue_e  issue,
    output sd_cmd_t cmd
);

    // Pure decode of the command choice
    always_comb begin
        case (issue)
            ISSUE_NOP: cmd = CMD_NOP;
            ISSUE_PRE: cmd = CMD_PRECHARGE;
            ISSUE_REF: cmd = CMD_REFRESH;
            default:   cmd = CMD_DESEL;
        endcase
    end

endmodule

// File: rtl/sdram_refresh_seq.sv
// SDRAM periodic refresh sequencer, top level.
// Raises a request when the interval expires and holds it until granted. Then it
// drives precharge, wait, auto-refresh and a dead cycle on the command pins.
// Assumes: the arbiter grants only when no access is in flight, and the access
// controller leaves the pins alone while ref_active is high.
module sdram_refresh_seq
    import sdram_ref_pkg::*;
#(
    parameter int INTERVAL_W = 14,
    parameter int WAIT_W     = 4,
    parameter int CMD_CYCLES = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [INTERVAL_W-1:0] cfg_interval,
    input  logic [WAIT_W-1:0]     cfg_pre_wait,
    input  logic                  ref_gnt,
    output logic                  ref_req,
    output logic                  ref_active,
    output logic                  sd_cs_n,
    output logic                  sd_ras_n,
    output logic                  sd_cas_n,
    output logic                  sd_we_n
);

    logic    pending;
    logic    busy;
    logic    take;
    issue_e  issue;
    sd_cmd_t cmd;

    // Request is withheld while a sequence runs; a grant is taken only on a shown request
    assign ref_req    = pending && !busy;
    assign take       = ref_req && ref_gnt;
    assign ref_active = busy;

    ref_interval_timer #(
        .INTERVAL_W(INTERVAL_W)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_interval (cfg_interval),
        .take         (take),
        .pending      (pending)
    );

    ref_seq_fsm #(
        .WAIT_W     (WAIT_W),
        .CMD_CYCLES (CMD_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (take),
        .cfg_pre_wait (cfg_pre_wait),
        .busy         (busy),
        .issue        (issue)
    );

    ref_cmd_encode u_enc (
        .issue (issue),
        .cmd   (cmd)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_active |-> (sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n)); // R1

    AST_GNT_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_gnt) |=> (ref_active && !ref_req)); // R5

endmodule

// File: tb/sim_sdram_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_refresh_seq;

    localparam logic [3:0] P_DESEL = 4'b1111;
    localparam logic [3:0] P_NOP   = 4'b0111;
    localparam logic [3:0] P_PRE   = 4'b0010;
    localparam logic [3:0] P_REF   = 4'b0001;

    // interval, wait setting, extra cycles the grant is held off
    localparam int NVEC = 6;
    localparam int VEC [NVEC][3] = '{
        '{40,    2, 0},
        '{64,    1, 5},
        '{100,   5, 20},
        '{30,    0, 3},
        '{1003,  3, 200},
        '{16383, 15, 0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] cfg_interval = '0;
    logic [3:0]  cfg_pre_wait = '0;
    logic        ref_gnt = 1'b0;
    logic        ref_req, ref_active, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [3:0]  pins;
    int          cyc = 0;
    int          n_chk = 0;
    int          n_bad = 0;
    int          wd = 0;

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always #2 clk = ~clk;

    sdram_refresh_seq u0 (
        .clk(clk), .rst_n(rst_n), .cfg_interval(cfg_interval), .cfg_pre_wait(cfg_pre_wait),
        .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_active(ref_active),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n)
    );

    // Edges since reset release
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Watchdog
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 190000) begin
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act %0d exp below 190000", wd);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act %0d exp %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int ival, input int pw);
        rst_n = 1'b0;
        ref_gnt = 1'b0;
        cfg_interval = 14'(ival);
        cfg_pre_wait = 4'(pw);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ref_req && !ref_active && pins == P_DESEL, "R1 reset state",
            {ref_req, ref_active, pins}, {2'b00, P_DESEL});
        rst_n = 1'b1;
    endtask

    task automatic wait_req(input int limit);
        while (!ref_req && cyc < limit) step();
    endtask

    // Walk one refresh sequence starting in the cycle after the grant
    task automatic walk_seq(input int pw, input string tag);
        int pe;
        int len;
        int bad;
        pe = (pw == 0) ? 1 : pw;
        len = 3 * pe + 5;
        bad = 0;
        chk(pins == P_PRE && !ref_req && ref_active, {tag, " R5 precharge first"},
            {ref_req, ref_active, pins}, {2'b01, P_PRE});
        for (int c = 2; c <= len; c++) begin
            step();
            if (c == 3 * pe + 1) begin
                chk(pins == P_REF && ref_active, {tag, " R6 refresh slot"}, pins, P_REF);
            end else if (pins != P_NOP || !ref_active) begin
                bad = bad + 1;
            end
        end
        chk(bad == 0, {tag, " R7 nop cycles"}, bad, 0);
        step();
        chk(!ref_active && pins == P_DESEL, {tag, " R7 sequence length"},
            {ref_active, pins}, {1'b0, P_DESEL});
    endtask

    initial begin
        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            int iv;
            int pw;
            int dl;
            int bad;
            iv = VEC[v][0];
            pw = VEC[v][1];
            dl = VEC[v][2];
            do_reset(iv, pw);
            @(negedge clk);
            wait_req(iv + 5);
            chk(ref_req && cyc == iv, "R2 first deadline", cyc, iv);
            bad = 0;
            for (int k = 0; k < dl; k++) begin
                step();
                if (!ref_req || pins != P_DESEL) bad = bad + 1;
            end
            chk(bad == 0, "R4 request held, pins quiet", bad, 0);
            ref_gnt = 1'b1;
            step();
            ref_gnt = 1'b0;
            walk_seq(pw, "vec");
            wait_req(2 * iv + 5);
            chk(ref_req && cyc == 2 * iv, "R2 second deadline", cyc, 2 * iv);
        end

        // R3: zero interval disables refresh
        begin
            int seen;
            do_reset(0, 2);
            seen = 0;
            for (int k = 0; k < 500; k++) begin
                step();
                if (ref_req || pins != P_DESEL) seen = seen + 1;
            end
            chk(seen == 0, "R3 disabled", seen, 0);
        end

        // R8: deadlines merged while grant held off
        do_reset(20, 1);
        while (cyc < 50) step();
        chk(ref_req, "R8 still requesting", ref_req, 1);
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        walk_seq(1, "merge");
        chk(cyc == 59 && !ref_req, "R8 no extra request", {cyc, 1'b0} | int'(ref_req), 59 * 2);
        step();
        chk(cyc == 60 && ref_req, "R2 deadline not shifted", int'(ref_req), 1);

        // R10: deadline on the grant edge
        do_reset(20, 1);
        while (cyc < 39) step();
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 8; k++) begin
                if (ref_req || !ref_active) bad = bad + 1;
                if (k < 7) step();
            end
            chk(bad == 0, "R9 no request during sequence", bad, 0);
        end
        step();
        chk(cyc == 48 && ref_req && !ref_active, "R10 new request after grant edge",
            int'(ref_req), 1);

        // R9: deadline inside a running sequence
        do_reset(10, 3);
        while (cyc < 10) step();
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 14; k++) begin
                if (ref_req) bad = bad + 1;
                step();
            end
            chk(bad == 0, "R9 withheld while active", bad, 0);
        end
        chk(cyc == 25 && ref_req && !ref_active, "R9 raised after sequence", int'(ref_req), 1);

        // R1: reset in the middle of a sequence
        ref_gnt = 1'b1;
        step();
        ref_gnt = 1'b0;
        step();
        do_reset(10, 3);
        step();
        chk(!ref_req && !ref_active && pins == P_DESEL, "R1 quiet after mid-sequence reset",
            {ref_req, ref_active, pins}, {2'b00, P_DESEL});

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule